// File: doc/BRIEF.md
# Target Address Window Decoder and Remapper

This block sits behind the target side of a 32-bit bus interface. It compares each incoming target address against five address windows: four general local spaces and one expansion-ROM space. When an address falls in a window, the block rewrites it into a 28-bit local address. Each window's size is held as a range mask, which is the two's complement of a power-of-two size. A mask bit of 1 means that address bit takes part in the decode. On a hit, every decoded bit is replaced by the matching bit of the window's local remap base, and the remaining offset bits pass through unchanged.

Each window's PCI base address comes from outside on an input bus. The range and remap registers are loaded through a simple write port. The write select has four bits: bit 3 picks the register (0 = range, 1 = remap) and bits [2:0] pick the window (0 to 3 = general spaces, 4 = expansion ROM). Any other window index is ignored. The write data holds local bits [27:0] only, so bits [31:28] of these registers do not exist.

When the address strobe is high, the block registers a result on that clock edge. The result is a one-hot hit vector, the translated local address and an I/O flag. In every other cycle, and on a miss, all three outputs are zero.

Top module: `addr_window_decoder`

## Requirements
- R1: A general window hits when it is enabled and every address bit whose range-mask bit is 1 equals the same bit of that window's base input. Bits below the window's lowest decode bit are ignored.
- R2: Address bits [31:28] always take part in the decode. An all-zero range mask therefore gives a window that decodes on those four bits only.
- R3: On a hit, the local address is the remap base in every decoded bit position of [27:0] and the incoming address in every other position.
- R4: A general window is enabled by remap-register bit 0, and the ROM window by range-register bit 0. A disabled window never hits, and a hit can be removed again by clearing that bit.
- R5: The ROM window decodes and remaps on bits [27:11] only. Remap bits [10:0] are ignored, so address bits [10:0] pass straight to the local address.
- R6: Range-register bit 0 of a general window selects I/O (1) or memory (0). In I/O mode, bits [27:2] decode and remap. In memory mode, bits [27:4] do, and range bits [3:2] have no effect. io_o is 1 only for a hit in an I/O-mode general window.
- R7: After reset, all outputs are zero and all windows are disabled. The general remap bases are 0, the ROM remap base is 0x0100000 (1 MB) and the ROM range mask gives a 64 KB window.
- R8: When several windows match, only the lowest-numbered one is reported. The ROM window (index 4) has the lowest priority.
- R9: The outputs show the result for the address sampled on the clock edge where the strobe is high. In the cycle after a cycle with no strobe, and on any miss, hit_o, loc_addr_o and io_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 4 | Register select: bit 3 picks remap (1) or range (0); bits [2:0] pick the window |
| cfg_wdata_i | input | 28 | Register write data, bits [27:0] |
| bar_base_i | input | 5x32 | PCI base address of each window; index 4 is the ROM window |
| strobe_i | input | 1 | Address strobe |
| addr_i | input | 32 | Target address |
| hit_o | output | 5 | One-hot window hit, all zero on a miss |
| loc_addr_o | output | 28 | Translated local address |
| io_o | output | 1 | Hit is in an I/O-mode window |

## Verification
Each result is due one clock edge after the edge that samples the strobe. A register write takes effect for strobes sampled on any later edge, but not for a strobe sampled on the same edge as the write. The bench's reference model follows this. On each rising edge it computes the expected triple from the old settings and only then applies any write. It compares that triple with the outputs at the next falling edge, halfway between the registering edge and the edge that follows, so every check lands in the cycle where the result is due. Idle cycles between probes are checked against all-zero outputs in the same way.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int ADDR_W = 32;
  localparam int LOC_W  = 28;

  typedef struct packed {
    logic              en;
    logic              io;
    logic [ADDR_W-1:0] mask;   // effective decode mask, top bits forced
    logic [LOC_W-1:0]  remap;
  } win_cfg_t;
endpackage

// File: rtl/addr_win_cfg.sv
module addr_win_cfg
  import addr_win_pkg::*;
#(
  parameter bit                IS_ROM  = 1'b0,
  parameter int                MEM_LSB = 4,
  parameter int                IO_LSB  = 2,
  parameter int                ROM_LSB = 11,
  parameter logic [LOC_W-1:0]  RNG_RST = '0,
  parameter logic [LOC_W-1:0]  RMP_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rng_we_i,
  input  logic             rmp_we_i,
  input  logic [LOC_W-1:0] wdata_i,
  output win_cfg_t         cfg_o
);
  localparam int TOP_W = ADDR_W - LOC_W;
  localparam int KEEP_LSB = IS_ROM ? ROM_LSB : IO_LSB;
  localparam int DEC_LSB  = IS_ROM ? ROM_LSB : MEM_LSB;
  localparam logic [LOC_W-1:0] KEEP     = {LOC_W{1'b1}} << KEEP_LSB;
  localparam logic [LOC_W-1:0] DEC_KEEP = {LOC_W{1'b1}} << DEC_LSB;

  logic [LOC_W-1:0] rng_q, rmp_q;
  logic             en_q, io_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rng_q <= RNG_RST & KEEP;
      rmp_q <= RMP_RST & KEEP;
    end else begin
      if (rng_we_i) rng_q <= wdata_i & KEEP;
      if (rmp_we_i) rmp_q <= wdata_i & KEEP;
    end
  end

  generate
    if (IS_ROM) begin : g_rom
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       en_q <= 1'b0;
        else if (rng_we_i) en_q <= wdata_i[0];
      end
      assign io_w = 1'b0;
    end else begin : g_gen
      logic io_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          en_q <= 1'b0;
          io_q <= 1'b0;
        end else begin
          if (rmp_we_i) en_q <= wdata_i[0];
          if (rng_we_i) io_q <= wdata_i[0];
        end
      end
      assign io_w = io_q;
    end
  endgenerate

  assign cfg_o.en    = en_q;
  assign cfg_o.io    = io_w;
  assign cfg_o.mask  = {{TOP_W{1'b1}}, rng_q & (io_w ? KEEP : DEC_KEEP)};
  assign cfg_o.remap = rmp_q;
endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
  import addr_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  win_cfg_t          cfg_i,
  output logic              hit_o,
  output logic [LOC_W-1:0]  loc_o
);
  logic [LOC_W-1:0] low_mask;
  assign low_mask = cfg_i.mask[LOC_W-1:0];
  assign hit_o = cfg_i.en && (((addr_i ^ base_i) & cfg_i.mask) == '0);
  // substitute decoded bits with the local base, keep the offset
  assign loc_o = (addr_i[LOC_W-1:0] & ~low_mask) | (cfg_i.remap & low_mask);
endmodule

// File: rtl/addr_win_sel.sv
module addr_win_sel
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            strobe_i,
  input  logic [NUM_WIN-1:0]              hit_i,
  input  logic [NUM_WIN-1:0][LOC_W-1:0]   loc_i,
  input  logic [NUM_WIN-1:0]              io_i,
  output logic [NUM_WIN-1:0]              hit_o,
  output logic [LOC_W-1:0]                loc_o,
  output logic                            io_o
);
  logic [NUM_WIN-1:0] pick;
  logic [LOC_W-1:0]   loc_d;
  logic               io_d, found;

  // lowest index wins
  always_comb begin
    pick  = '0;
    loc_d = '0;
    io_d  = 1'b0;
    found = 1'b0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (!found && hit_i[k]) begin
        found   = 1'b1;
        pick[k] = 1'b1;
        loc_d   = loc_i[k];
        io_d    = io_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= '0;
      loc_o <= '0;
      io_o  <= 1'b0;
    end else if (strobe_i) begin
      hit_o <= pick;
      loc_o <= loc_d;
      io_o  <= io_d;
    end else begin
      hit_o <= '0;
      loc_o <= '0;
      io_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int               NUM_GEN = 4,
  parameter int               MEM_LSB = 4,
  parameter int               IO_LSB  = 2,
  parameter int               ROM_LSB = 11,
  parameter logic [LOC_W-1:0] ROM_RNG_RST = 28'hFFF_0000,
  parameter logic [LOC_W-1:0] ROM_RMP_RST = 28'h010_0000,
  localparam int              NUM_WIN = NUM_GEN + 1,
  localparam int              IDX_W   = $clog2(NUM_WIN),
  localparam int              SEL_W   = IDX_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_we_i,
  input  logic [SEL_W-1:0]               cfg_sel_i,
  input  logic [LOC_W-1:0]               cfg_wdata_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] bar_base_i,
  input  logic                           strobe_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic [NUM_WIN-1:0]             hit_o,
  output logic [LOC_W-1:0]               loc_addr_o,
  output logic                           io_o
);
  win_cfg_t [NUM_WIN-1:0]            win_cfg;
  logic [NUM_WIN-1:0]                win_en, win_io, win_hit;
  logic [NUM_WIN-1:0][LOC_W-1:0]     win_loc;

  generate
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      logic sel_k, rng_we, rmp_we;
      assign sel_k  = cfg_we_i && (cfg_sel_i[IDX_W-1:0] == IDX_W'(k));
      assign rng_we = sel_k && !cfg_sel_i[SEL_W-1];
      assign rmp_we = sel_k &&  cfg_sel_i[SEL_W-1];

      addr_win_cfg #(
        .IS_ROM  (k == NUM_GEN),
        .MEM_LSB (MEM_LSB),
        .IO_LSB  (IO_LSB),
        .ROM_LSB (ROM_LSB),
        .RNG_RST ((k == NUM_GEN) ? ROM_RNG_RST : '0),
        .RMP_RST ((k == NUM_GEN) ? ROM_RMP_RST : '0)
      ) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rng_we_i (rng_we),
        .rmp_we_i (rmp_we),
        .wdata_i  (cfg_wdata_i),
        .cfg_o    (win_cfg[k])
      );

      addr_win_match u_match (
        .addr_i (addr_i),
        .base_i (bar_base_i[k]),
        .cfg_i  (win_cfg[k]),
        .hit_o  (win_hit[k]),
        .loc_o  (win_loc[k])
      );

      assign win_en[k] = win_cfg[k].en;
      assign win_io[k] = win_cfg[k].io;
    end
  endgenerate

  addr_win_sel #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .hit_i    (win_hit),
    .loc_i    (win_loc),
    .io_i     (win_io),
    .hit_o    (hit_o),
    .loc_o    (loc_addr_o),
    .io_o     (io_o)
  );
endmodule

// File: rtl/addr_win_chk.sv
module addr_win_chk
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           strobe_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] bar_base_i,
  input logic [NUM_WIN-1:0]             win_en,
  input logic [NUM_WIN-1:0]             hit_o,
  input logic [LOC_W-1:0]               loc_addr_o,
  input logic                           io_o
);
  // R8: at most one window reported
  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));

  // R9: no strobe -> all-zero result next cycle
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> (hit_o == '0 && loc_addr_o == '0 && !io_o));

  // R9: a miss carries no address or io flag
  a_r9_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == '0) |-> (loc_addr_o == '0 && !io_o));

  // R6: the ROM window is never I/O
  a_r6_rom_not_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o[NUM_WIN-1] |-> !io_o);

  generate
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_w
      // R4: disabled window never hits
      a_r4_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && !win_en[k]) |=> !hit_o[k]);
      // R2: top address bits always decoded
      a_r2_top_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_i && (addr_i[ADDR_W-1:LOC_W] != bar_base_i[k][ADDR_W-1:LOC_W]))
        |=> !hit_o[k]);
    end
  endgenerate
endmodule

bind addr_window_decoder addr_win_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .addr_i     (addr_i),
  .bar_base_i (bar_base_i),
  .win_en     (win_en),
  .hit_o      (hit_o),
  .loc_addr_o (loc_addr_o),
  .io_o       (io_o)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [3:0]        cfg_sel_i = '0;
  logic [27:0]       cfg_wdata_i = '0;
  logic [4:0][31:0]  bar_base_i = '0;
  logic              strobe_i = 1'b0;
  logic [31:0]       addr_i = '0;
  logic [4:0]        hit_o;
  logic [27:0]       loc_addr_o;
  logic              io_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string req = "R9";
  string exp_req = "R9";

  always #2 clk_i = ~clk_i;

  addr_window_decoder dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .bar_base_i,
    .strobe_i, .addr_i, .hit_o, .loc_addr_o, .io_o
  );

  // behavioural reference model
  logic [27:0] m_rng [5];
  logic [27:0] m_rmp [5];
  logic [4:0]  e_hit;
  logic [27:0] e_loc;
  logic        e_io;

  function automatic logic [31:0] m_mask(int k);
    int lsb;
    if (k == 4) lsb = 11;
    else        lsb = m_rng[k][0] ? 2 : 4;
    return 32'hF000_0000 | ({4'h0, m_rng[k]} & ~((32'd1 << lsb) - 1));
  endfunction

  function automatic bit m_en(int k);
    return (k == 4) ? m_rng[4][0] : m_rmp[k][0];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 4; k++) begin m_rng[k] = '0; m_rmp[k] = '0; end
      m_rng[4] = 28'hFFF_0000;
      m_rmp[4] = 28'h010_0000;
      e_hit = '0; e_loc = '0; e_io = 1'b0;
    end else begin
      e_hit = '0; e_loc = '0; e_io = 1'b0;
      exp_req = req;
      if (strobe_i) begin
        for (int k = 0; k < 5; k++) begin
          logic [31:0] m;
          m = m_mask(k);
          if (e_hit == '0 && m_en(k) && (((addr_i ^ bar_base_i[k]) & m) == 0)) begin
            e_hit[k] = 1'b1;
            e_loc = (addr_i[27:0] & ~m[27:0]) | (m_rmp[k] & m[27:0]);
            e_io = (k < 4) && m_rng[k][0];
          end
        end
      end
      if (cfg_we_i && cfg_sel_i[2:0] < 5) begin
        if (cfg_sel_i[3]) m_rmp[cfg_sel_i[2:0]] = cfg_wdata_i;
        else              m_rng[cfg_sel_i[2:0]] = cfg_wdata_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (hit_o !== e_hit || loc_addr_o !== e_loc || io_o !== e_io) begin
        errors++;
        $display("FAIL %s: hit=%b loc=%h io=%b expected hit=%b loc=%h io=%b",
                 exp_req, hit_o, loc_addr_o, io_o, e_hit, e_loc, e_io);
      end
    end
  end

  task automatic wr(input logic [3:0] sel, input logic [27:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input string r);
    req = r; strobe_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    strobe_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bar_base_i[0] = 32'h8000_0000;
    bar_base_i[1] = 32'h9000_0000;
    bar_base_i[2] = 32'h0000_1000;
    bar_base_i[3] = 32'hA000_0000;
    bar_base_i[4] = 32'hC000_0000;
    repeat (3) @(negedge clk_i);
    checks++;  // R7 reset state
    if (hit_o !== '0 || loc_addr_o !== '0 || io_o !== 1'b0) begin
      errors++;
      $display("FAIL R7: hit=%b loc=%h io=%b expected all zero", hit_o, loc_addr_o, io_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    probe(32'h8000_0000, "R7");   // all disabled after reset
    probe(32'hC000_0000, "R7");
    // window 0: 4 KB memory, local base 0x1234000
    wr(4'b0000, 28'hFFF_F000);
    wr(4'b1000, 28'h123_4001);
    probe(32'h8000_0ABC, "R1");
    probe(32'h8000_1ABC, "R1");
    probe(32'h8000_0004, "R3");
    // window 1: empty mask decodes top bits only
    wr(4'b0001, 28'h000_0000);
    wr(4'b1001, 28'h500_0001);
    probe(32'h9ABC_DEF0, "R2");
    probe(32'h1ABC_DEF0, "R2");
    // window 2: I/O, 4-byte window
    wr(4'b0010, 28'hFFF_FFFD);
    wr(4'b1010, 28'h000_0109);
    probe(32'h0000_1003, "R6");
    probe(32'h0000_1004, "R6");
    // window 3: memory, range bits [3:2] set have no effect
    wr(4'b0011, 28'hFFF_FFFC);
    wr(4'b1011, 28'hAB0_000D);
    probe(32'hA000_000C, "R6");
    probe(32'hA000_0010, "R6");
    // ROM: enable with 64 KB mask, default 1 MB base
    wr(4'b0100, 28'hFFF_0001);
    probe(32'hC000_1234, "R7");
    // ROM: 2 KB window, low remap bits ignored
    wr(4'b0100, 28'hFFF_F801);
    wr(4'b1100, 28'h020_07FF);
    probe(32'hC000_07FF, "R5");
    probe(32'hC000_0800, "R5");
    // priority: windows 0, 1 and ROM overlap
    wr(4'b0001, 28'hFFF_FF00);
    bar_base_i[1] = 32'h8000_0000;
    bar_base_i[4] = 32'h8000_0000;
    probe(32'h8000_0010, "R8");
    wr(4'b1000, 28'h123_4000);    // disable window 0
    probe(32'h8000_0010, "R4");
    wr(4'b1001, 28'h500_0000);    // disable window 1
    probe(32'h8000_0010, "R8");
    // back-to-back strobes then idle
    req = "R9"; strobe_i = 1'b1; addr_i = 32'h8000_0020;
    @(negedge clk_i);
    addr_i = 32'h9000_0000;
    @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule